// File: doc/BRIEF.md
# Flash Page-Buffer Programming Controller

This block fronts a small non-volatile array, modelled here as a register array. Software fills a one-page buffer by writing words to array addresses. It then commits the buffer with a keyed command, or lets the controller commit it on its own. Every command carries a key byte and an operation code. The commands are: row erase, page write, buffer clear, region lock, region unlock, and entering or leaving a low-power state.

Programming models flash behaviour: a committed page is the bitwise AND of the old contents and the buffer, so a commit can only clear bits. Erase is the only way to return a row to all ones. While an erase or a page commit is running, `ready` is low and the bus side is stalled. Rows in a locked region, and rows inside the boot area set by `boot_prot`, refuse both erase and commit. In that case a lock error is recorded.

Default geometry: 16 words of 32 bits per page, 4 pages per row, 32 rows, and lock regions of 4 rows each. The word address splits into the row (bits 10:6), the page (bits 5:4) and the word in the page (bits 3:0).

Top module: `flash_pgm_ctrl`

## Requirements
- R1: After reset, `ready`=1, `lock_err`=0, `prog_err`=0 and `prm`=0. Every array word reads 0xFFFFFFFF, the page buffer holds all ones, and no region is locked.
- R2: A command takes effect only when `cmd_key`=0xA5 and `cmd_op` is nonzero. Any other command is ignored and sets `prog_err`.
- R3: A command issued while `ready`=0 is ignored and sets `prog_err`. `status_clr`=1 clears `prog_err` and `lock_err`. An error raised in the same cycle as the clear wins over the clear.
- R4: The operation codes are 1 = erase row, 2 = write page, 3 = clear buffer, 4 = lock region, 5 = unlock region, 6 = enter low power, 7 = leave low power. Erase row (op 1) drives `ready` low for exactly 8 cycles after the command edge. It then sets every word of the row that holds the address register to 0xFFFFFFFF; any address inside the row selects the row.
- R5: Write page (op 2) drives `ready` low for exactly 4 cycles. It then stores old AND buffer into every word of the page that holds the address register, and resets the buffer to all ones.
- R6: With `manual_mode`=0, a bus write to word 15 of a page starts a 4-cycle commit of that page. A bus write to any other word starts nothing.
- R7: With `manual_mode`=1, no bus write starts a commit, including a write to word 15.
- R8: Clear buffer (op 3) sets the buffer to all ones without touching the array.
- R9: Lock (op 4) and unlock (op 5) act on the 4-row region that holds the address register. An erase or commit aimed at a locked row leaves the array unchanged, keeps `ready` high and sets `lock_err`. A refused commit still resets the buffer to all ones.
- R10: `boot_prot` protects rows starting at row 0 in the same way as a lock. Code 7 protects 0 rows, and each lower code doubles the count: 6 protects 2, 5 protects 4, 4 protects 8, and so on down to code 0, which protects 128.
- R11: Op 6 sets `prm` to 1 and op 7 clears it.
- R12: A bus write or `addr_wr` while `ready`=0 is ignored. A bus write loads the address register with its address. A bus write in the same cycle as `cmd_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| manual_mode | input | 1 | 1: commit only by command; 0: auto-commit on word 15 |
| boot_prot | input | 3 | Boot-area size code |
| bus_we | input | 1 | Bus write into page buffer |
| bus_addr | input | 11 | Bus word address (read and write) |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Array word at `bus_addr` |
| addr_wr | input | 1 | Load the address register |
| addr_wdata | input | 11 | Address register value |
| cmd_valid | input | 1 | Command strobe |
| cmd_key | input | 8 | Command key |
| cmd_op | input | 3 | Operation code |
| status_clr | input | 1 | Clear error flags |
| ready | output | 1 | Low while an erase or commit runs |
| lock_err | output | 1 | Sticky refused-by-protection flag |
| prog_err | output | 1 | Sticky bad-command flag |
| prm | output | 1 | Low-power state active |

## Verification
The embedded assertions check, on every cycle, the error flags' response to bad keys and to commands while busy. They also check that `ready` only falls after a command or bus write, that protected erases are refused without going busy, that the low-power flag follows its command, and that the address register is frozen while busy. The bench's behavioural model covers the array contents: the AND rule, erased rows, the buffer reset after a commit or a refusal, the exact busy length of each operation, and the boot-code row counts. These appear only by reading the array back after the scenarios.

// File: rtl/flash_pgm_ctrl.sv
module flash_pgm_ctrl #(
  parameter int DW = 32,
  parameter int PAGE_WORDS = 16,
  parameter int PAGES_PER_ROW = 4,
  parameter int ROWS = 32,
  parameter int ROWS_PER_REGION = 4,
  parameter int ERASE_CYCLES = 8,
  parameter int WRITE_CYCLES = 4,
  parameter logic [7:0] KEY = 8'hA5,
  localparam int WB = $clog2(PAGE_WORDS),
  localparam int PB = $clog2(PAGES_PER_ROW),
  localparam int RB = $clog2(ROWS),
  localparam int AW = WB + PB + RB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          manual_mode,
  input  logic [2:0]    boot_prot,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          addr_wr,
  input  logic [AW-1:0] addr_wdata,
  input  logic          cmd_valid,
  input  logic [7:0]    cmd_key,
  input  logic [2:0]    cmd_op,
  input  logic          status_clr,
  output logic          ready,
  output logic          lock_err,
  output logic          prog_err,
  output logic          prm
);
  localparam int WORDS = ROWS * PAGES_PER_ROW * PAGE_WORDS;
  localparam int ROW_WORDS = PAGES_PER_ROW * PAGE_WORDS;
  localparam int REGIONS = ROWS / ROWS_PER_REGION;
  localparam int RGB = $clog2(REGIONS);
  localparam int MAXC = (ERASE_CYCLES > WRITE_CYCLES) ? ERASE_CYCLES : WRITE_CYCLES;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [2:0] OP_ERASE = 3'd1, OP_WRPG = 3'd2, OP_CLRBUF = 3'd3,
                         OP_LOCK = 3'd4, OP_UNLOCK = 3'd5, OP_SPRM = 3'd6, OP_CPRM = 3'd7;

  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] pbuf [PAGE_WORDS];
  logic [AW-1:0] addr_q, tgt_q, tgt_addr;
  logic [REGIONS-1:0] lock_q;
  logic [CW-1:0] busy_cnt;
  logic erase_q;

  logic cmd_ok, cmd_bad, wr_ok, auto_go, prot, do_erase, do_write;
  logic [RB-1:0] tgt_row, cmd_row;

  function automatic int boot_rows(input logic [2:0] c);
    return (c == 3'd7) ? 0 : (1 << (7 - int'(c)));
  endfunction

  assign ready     = (busy_cnt == '0);
  assign bus_rdata = mem[bus_addr];
  assign cmd_ok    = cmd_valid && cmd_key == KEY && ready && cmd_op != 3'd0;
  assign cmd_bad   = cmd_valid && !cmd_ok;
  assign wr_ok     = bus_we && ready && !cmd_valid;
  assign auto_go   = wr_ok && !manual_mode && bus_addr[WB-1:0] == WB'(PAGE_WORDS - 1);
  assign tgt_addr  = auto_go ? bus_addr : addr_q;
  assign tgt_row   = tgt_addr[AW-1 -: RB];
  assign cmd_row   = addr_q[AW-1 -: RB];
  assign prot      = lock_q[tgt_row[RB-1 -: RGB]] || (int'(tgt_row) < boot_rows(boot_prot));
  assign do_erase  = cmd_ok && cmd_op == OP_ERASE;
  assign do_write  = (cmd_ok && cmd_op == OP_WRPG) || auto_go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
      for (int i = 0; i < PAGE_WORDS; i++) pbuf[i] <= '1;
      addr_q <= '0;
      tgt_q <= '0;
      lock_q <= '0;
      busy_cnt <= '0;
      erase_q <= 1'b0;
      lock_err <= 1'b0;
      prog_err <= 1'b0;
      prm <= 1'b0;
    end else begin
      if (status_clr) begin
        lock_err <= 1'b0;
        prog_err <= 1'b0;
      end
      if (cmd_bad) prog_err <= 1'b1;
      if (addr_wr && ready) addr_q <= addr_wdata;
      if (wr_ok) begin
        pbuf[bus_addr[WB-1:0]] <= bus_wdata;
        addr_q <= bus_addr;
      end
      if (cmd_ok) begin
        case (cmd_op)
          OP_CLRBUF: for (int i = 0; i < PAGE_WORDS; i++) pbuf[i] <= '1;
          OP_LOCK:   lock_q[cmd_row[RB-1 -: RGB]] <= 1'b1;
          OP_UNLOCK: lock_q[cmd_row[RB-1 -: RGB]] <= 1'b0;
          OP_SPRM:   prm <= 1'b1;
          OP_CPRM:   prm <= 1'b0;
          default: ;
        endcase
      end
      if (do_erase) begin
        if (prot) lock_err <= 1'b1;
        else begin
          busy_cnt <= CW'(ERASE_CYCLES);
          erase_q <= 1'b1;
          tgt_q <= tgt_addr;
        end
      end
      if (do_write) begin
        if (prot) begin
          lock_err <= 1'b1;
          for (int i = 0; i < PAGE_WORDS; i++) pbuf[i] <= '1;
        end else begin
          busy_cnt <= CW'(WRITE_CYCLES);
          erase_q <= 1'b0;
          tgt_q <= tgt_addr;
        end
      end
      if (!ready) begin
        busy_cnt <= busy_cnt - 1'b1;
        if (busy_cnt == CW'(1)) begin
          if (erase_q) begin
            for (int i = 0; i < ROW_WORDS; i++)
              mem[AW'(int'(tgt_q[AW-1 -: RB]) * ROW_WORDS + i)] <= '1;
          end else begin
            for (int i = 0; i < PAGE_WORDS; i++) begin
              mem[AW'(int'(tgt_q[AW-1:WB]) * PAGE_WORDS + i)] <=
                mem[AW'(int'(tgt_q[AW-1:WB]) * PAGE_WORDS + i)] & pbuf[i];
              pbuf[i] <= '1;
            end
          end
        end
      end
    end
  end

  // R2
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_key != KEY) |=> prog_err);
  // R3
  busy_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !ready) |=> (prog_err && $stable(lock_q) && $stable(prm)));
  // R4
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(cmd_valid || bus_we));
  // R9
  lock_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_erase && prot) |=> (lock_err && ready));
  // R11
  prm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && cmd_op == OP_SPRM) |=> prm);
  // R12
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(addr_q));
endmodule

// File: tb/flash_pgm_ctrl_tb.sv
module flash_pgm_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic manual_mode = 1;
  logic [2:0] boot_prot = 3'd7;
  logic bus_we = 0, addr_wr = 0, cmd_valid = 0, status_clr = 0;
  logic [10:0] bus_addr = 0, addr_wdata = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [7:0] cmd_key = 0;
  logic [2:0] cmd_op = 0;
  logic ready, lock_err, prog_err, prm;

  int checks = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  flash_pgm_ctrl u_dut (.clk, .rst_n, .manual_mode, .boot_prot, .bus_we, .bus_addr,
    .bus_wdata, .bus_rdata, .addr_wr, .addr_wdata, .cmd_valid, .cmd_key, .cmd_op,
    .status_clr, .ready, .lock_err, .prog_err, .prm);

  // behavioural reference
  logic [31:0] m_mem [2048];
  logic [31:0] m_buf [16];
  int m_busy, m_lock [8];
  bit m_erase, m_lerr, m_perr, m_prm;
  int m_addr, m_tgt;

  function automatic int brows(input int c);
    return c == 7 ? 0 : (1 << (7 - c));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 32'hFFFF_FFFF;
      foreach (m_buf[i]) m_buf[i] = 32'hFFFF_FFFF;
      foreach (m_lock[i]) m_lock[i] = 0;
      m_busy = 0; m_lerr = 0; m_perr = 0; m_prm = 0; m_addr = 0; m_tgt = 0; m_erase = 0;
    end else begin
      bit idle, good, wr, autoc, pr;
      int old_addr, t, row;
      idle = (m_busy == 0);
      old_addr = m_addr;
      good = cmd_valid && cmd_key == 8'hA5 && idle && cmd_op != 0;
      wr = bus_we && idle && !cmd_valid;
      autoc = wr && !manual_mode && (bus_addr % 16) == 15;
      if (status_clr) begin m_lerr = 0; m_perr = 0; end
      if (cmd_valid && !good) m_perr = 1;
      if (!idle) begin
        m_busy--;
        if (m_busy == 0) begin
          if (m_erase) for (int i = 0; i < 64; i++) m_mem[(m_tgt / 64) * 64 + i] = 32'hFFFF_FFFF;
          else for (int i = 0; i < 16; i++) begin
            m_mem[(m_tgt / 16) * 16 + i] &= m_buf[i];
            m_buf[i] = 32'hFFFF_FFFF;
          end
        end
      end
      if (addr_wr && idle) m_addr = addr_wdata;
      if (wr) begin m_buf[bus_addr % 16] = bus_wdata; m_addr = bus_addr; end
      t = autoc ? int'(bus_addr) : old_addr;
      row = t / 64;
      pr = (m_lock[row / 4] != 0) || row < brows(boot_prot);
      if (good) case (cmd_op)
        3: foreach (m_buf[i]) m_buf[i] = 32'hFFFF_FFFF;
        4: m_lock[(old_addr / 64) / 4] = 1;
        5: m_lock[(old_addr / 64) / 4] = 0;
        6: m_prm = 1;
        7: m_prm = 0;
        default: ;
      endcase
      if (good && cmd_op == 1) begin
        if (pr) m_lerr = 1; else begin m_busy = 8; m_erase = 1; m_tgt = t; end
      end
      if ((good && cmd_op == 2) || autoc) begin
        if (pr) begin m_lerr = 1; foreach (m_buf[i]) m_buf[i] = 32'hFFFF_FFFF; end
        else begin m_busy = 4; m_erase = 0; m_tgt = t; end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R4 ready", ready, m_busy == 0);
      chk("R9 lock_err", lock_err, m_lerr);
      chk("R2 prog_err", prog_err, m_perr);
      chk("R11 prm", prm, m_prm);
      chk("R5 rdata", bus_rdata, m_mem[bus_addr]);
    end
    if (cyc > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  task automatic cmd(input logic [2:0] op, input logic [7:0] key = 8'hA5);
    @(posedge clk); #1 cmd_valid = 1; cmd_op = op; cmd_key = key;
    @(posedge clk); #1 cmd_valid = 0;
  endtask
  task automatic set_addr(input int a);
    @(posedge clk); #1 addr_wr = 1; addr_wdata = 11'(a);
    @(posedge clk); #1 addr_wr = 0;
  endtask
  task automatic bwr(input int a, input logic [31:0] d);
    @(posedge clk); #1 bus_we = 1; bus_addr = 11'(a); bus_wdata = d;
    @(posedge clk); #1 bus_we = 0;
  endtask
  task automatic rd(input string tag, input int a, input logic [31:0] exp);
    bus_addr = 11'(a); #1 chk(tag, bus_rdata, exp);
  endtask
  task automatic busy_len(input string tag, input int exp);
    int n = 0;
    while (!ready) begin n++; @(negedge clk); end
    chk(tag, n, exp);
  endtask
  task automatic clr();
    @(posedge clk); #1 status_clr = 1; @(posedge clk); #1 status_clr = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", ready, 1); chk("R1 prog_err", prog_err, 0);
    chk("R1 lock_err", lock_err, 0); chk("R1 prm", prm, 0);
    rd("R1 array", 0, 32'hFFFF_FFFF); rd("R1 array", 2047, 32'hFFFF_FFFF);
    // R2 wrong key
    cmd(3'd6, 8'h5A); #1 chk("R2 bad key", prog_err, 1); chk("R2 ignored", prm, 0);
    clr(); #1 chk("R3 clear", prog_err, 0);
    cmd(3'd0); #1 chk("R2 op zero", prog_err, 1);
    clr();
    // R7 manual mode: full page buffer, no auto commit
    for (int i = 0; i < 16; i++) bwr(2 * 64 + 16 + i, 32'h1234_0000 + i);
    #1 chk("R7 no commit", ready, 1); rd("R7 unchanged", 2 * 64 + 16 + 15, 32'hFFFF_FFFF);
    cmd(3'd2); @(negedge clk); busy_len("R5 write length", 4);
    rd("R5 data", 2 * 64 + 16 + 3, 32'h1234_0003);
    // R5 AND rule and buffer reset
    bwr(2 * 64 + 16 + 3, 32'hFFFF_00F0); cmd(3'd2);
    // R3 command while busy
    cmd(3'd6); #1 chk("R3 busy cmd", prog_err, 1); chk("R3 ignored", prm, 0);
    @(negedge clk); while (!ready) @(negedge clk);
    rd("R5 and", 2 * 64 + 16 + 3, 32'h1234_0000);
    rd("R5 buf reset", 2 * 64 + 16 + 5, 32'h1234_0005);
    clr();
    // R4 erase row 2, any address in row
    set_addr(2 * 64 + 37); cmd(3'd1); @(negedge clk); busy_len("R4 erase length", 8);
    rd("R4 erased", 2 * 64 + 16 + 3, 32'hFFFF_FFFF);
    // R6 auto mode
    manual_mode = 0;
    for (int i = 0; i < 15; i++) bwr(3 * 64 + i, 32'h0F0F_0000 + i);
    #1 chk("R6 no early commit", ready, 1);
    bwr(3 * 64 + 15, 32'h0F0F_000F); @(negedge clk); busy_len("R6 auto length", 4);
    rd("R6 data", 3 * 64 + 15, 32'h0F0F_000F); rd("R6 data", 3 * 64, 32'h0F0F_0000);
    manual_mode = 1;
    // R8 clear buffer
    bwr(4 * 64, 32'h0); cmd(3'd3); cmd(3'd2); @(negedge clk); while (!ready) @(negedge clk);
    rd("R8 cleared", 4 * 64, 32'hFFFF_FFFF);
    // R9 lock region 2 (rows 8..11)
    set_addr(8 * 64); cmd(3'd4);
    set_addr(9 * 64 + 5); cmd(3'd1); #1 chk("R9 no busy", ready, 1); chk("R9 lock_err", lock_err, 1);
    bwr(10 * 64 + 2, 32'h0); cmd(3'd2); @(negedge clk);
    rd("R9 write refused", 10 * 64 + 2, 32'hFFFF_FFFF);
    clr(); cmd(3'd5); cmd(3'd2); @(negedge clk); while (!ready) @(negedge clk);
    rd("R9 buf reset after refusal", 10 * 64 + 2, 32'hFFFF_FFFF);
    chk("R9 unlocked no error", lock_err, 0);
    // R10 boot protection
    boot_prot = 3'd6;
    set_addr(1 * 64); cmd(3'd1); #1 chk("R10 row1 protected", lock_err, 1);
    clr(); set_addr(2 * 64); cmd(3'd1); #1 chk("R10 row2 open", ready, 0);
    @(negedge clk); while (!ready) @(negedge clk);
    boot_prot = 3'd4; set_addr(7 * 64); cmd(3'd1); #1 chk("R10 row7 protected", lock_err, 1);
    boot_prot = 3'd7; clr();
    // R11 low power
    cmd(3'd6); #1 chk("R11 set", prm, 1); cmd(3'd7); #1 chk("R11 clear", prm, 0);
    // R12 bus write while busy ignored
    set_addr(5 * 64); cmd(3'd1);
    bwr(5 * 64 + 1, 32'h0); set_addr(6 * 64);
    @(negedge clk); while (!ready) @(negedge clk);
    cmd(3'd2); @(negedge clk); while (!ready) @(negedge clk);
    rd("R12 write ignored", 5 * 64 + 1, 32'hFFFF_FFFF);
    rd("R12 addr ignored", 6 * 64 + 1, 32'hFFFF_FFFF);
    repeat (4) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule